// File: doc/BRIEF.md
# Read-Strobe Delay Window Trainer

This block calibrates the read-strobe delay of one byte lane of a DDR data path per run. A start pulse selects a lane and forces that lane's 5-bit delay code to zero. The engine then reads an eight-byte reference pattern back through a simple read port, one byte per request. It raises the delay code step by step until every byte of a pass matches: that code is the opening edge of the passing window. It then keeps raising the code until a pass fails: that code is the closing edge. Finally it programs the midpoint of the window into the lane's delay register.

Before each byte read the engine pulses a FIFO reset toward the PHY and a clear of the controller's sticky read-error status. A read fails if the byte differs from the reference, or if the response carries a masked-data or dummy-data flag. Running out of delay range in either search phase stops training with an error and leaves the code where it is. Completion is reported by a single-cycle done pulse and a two-bit result.

Top module: `strobe_trainer`

## Requirements
- R1: After reset, result_o is 2'b00 (OK), done_o is 0, every lane's delay code is 0, and no read request or reset pulse is driven.
- R2: A start_i while idle forces the selected lane's code to 0 at the next edge, and result_o reads 2'b01 (busy) until completion. A done_o pulse never carries the busy code.
- R3: Pattern byte i of lane L is requested at address BASE + L + 4*i. Byte i is expected to be 0xFE for i = 0 and 0x11*(2i-1) for i = 1..7, which gives FE, 11, 33, 55, 77, 99, BB, DD.
- R4: Each byte request is preceded by a cycle that pulses fifo_rst_o and err_clr_o together. A successful run gives one further fifo_rst_o pulse before it completes, so that run has one more FIFO reset than reads.
- R5: A read request keeps rd_req_valid_o high and its address stable until rd_req_ready_i accepts it. The data and flags are evaluated only when rd_rsp_valid_i is high.
- R6: A response with rd_rsp_masked_i or rd_rsp_dummy_i set counts as a failed byte, even when the data matches.
- R7: In the first phase, any failed byte raises the code by one and restarts the pass at byte 0. The first phase ends with a fully matching pass, and its code becomes the window start.
- R8: In the second phase, a fully matching pass raises the code by one and retries. The first failed byte ends the phase, and the code at that point becomes the window end.
- R9: If a raise is needed while the code is 31, the run ends with result 2'b10 (error) and the code stays at 31.
- R10: On success the lane's code becomes start + ((end - start) >> 1), with result 2'b00.
- R11: done_o is a single-cycle pulse, and result_o holds its final value until the next start.
- R12: A start_i during a run is ignored, and lanes other than the selected one keep their codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin training the lane on lane_i |
| lane_i | input | LANE_W (2) | Lane to train |
| rd_req_valid_o | output | 1 | Byte read request valid |
| rd_req_ready_i | input | 1 | Memory side accepts the request |
| rd_req_addr_o | output | ADDR_W (12) | Byte address of the request |
| rd_rsp_valid_i | input | 1 | Read response valid |
| rd_rsp_data_i | input | 8 | Returned byte |
| rd_rsp_masked_i | input | 1 | Masked-data error on this read |
| rd_rsp_dummy_i | input | 1 | Dummy-data error on this read |
| fifo_rst_o | output | 1 | PHY read FIFO reset pulse |
| err_clr_o | output | 1 | Clear of the sticky read-error status |
| dly_code_o | output | LANES*CODE_W (20) | Delay code per lane, lane 0 in the low bits |
| done_o | output | 1 | Training finished, one cycle |
| result_o | output | 2 | 00 OK, 01 busy, 10 error |

## Verification
The hardest case to reach is a byte that fails from its flags alone while its data matches. A close second is a failure deep inside a pass that would otherwise succeed, because that failure must restart or end the search at exactly that code. The bench memory model passes reads only for codes inside a window chosen per run. It can also inject one fault at a chosen code and byte index: corrupt data, masked flag or dummy flag. Windows are swept from the bottom to the top of the range, so both saturation errors are reached, and a run is given a second start mid-flight.

// File: rtl/strb_pkg.sv
package strb_pkg;

   localparam int PAT_LEN     = 8;
   localparam int LANE_STRIDE = 4;

   typedef enum logic [1:0] {
      RES_OK   = 2'b00,
      RES_BUSY = 2'b01,
      RES_ERR  = 2'b10
   } train_res_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PREP,
      ST_REQ,
      ST_WAIT,
      ST_FIN
   } seq_st_e;

   // Reference byte i: 0xFE first, then odd multiples of 0x11.
   function automatic logic [7:0] pattern_byte(input int unsigned idx);
      logic [31:0] v;
      if (idx == 0) v = 32'hFE;
      else          v = 32'd17 * (2 * idx - 32'd1);
      return v[7:0];
   endfunction

endpackage

// File: rtl/strb_byte_check.sv
module strb_byte_check
   import strb_pkg::*;
#(
   parameter int IDX_W = 3
) (
   input  logic [IDX_W-1:0] idx_i,
   input  logic [7:0]       data_i,
   input  logic             masked_i,
   input  logic             dummy_i,
   output logic             ok_o
);

   logic [7:0] ref_lut [PAT_LEN];

   for (genvar g = 0; g < PAT_LEN; g++) begin : g_lut
      assign ref_lut[g] = pattern_byte(g);
   end

   always_comb begin
      ok_o = (data_i == ref_lut[idx_i]) && !masked_i && !dummy_i;
   end

endmodule

// File: rtl/strb_lane_delays.sv
module strb_lane_delays #(
   parameter int LANES  = 4,
   parameter int CODE_W = 5,
   parameter int LANE_W = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en_i,
   input  logic [LANE_W-1:0]       wr_lane_i,
   input  logic [CODE_W-1:0]       wr_code_i,
   output logic [LANES*CODE_W-1:0] codes_o
);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [CODE_W-1:0] code_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                       code_q <= '0;
         else if (wr_en_i && (wr_lane_i == LANE_W'(g)))    code_q <= wr_code_i;
      end

      assign codes_o[g*CODE_W +: CODE_W] = code_q;
   end

endmodule

// File: rtl/strb_sweep_fsm.sv
module strb_sweep_fsm
   import strb_pkg::*;
#(
   parameter int          LANES  = 4,
   parameter int          CODE_W = 5,
   parameter int          LANE_W = 2,
   parameter int          IDX_W  = 3,
   parameter int          ADDR_W = 12,
   parameter logic [31:0] BASE   = 32'h100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [LANE_W-1:0] lane_i,
   output logic              req_valid_o,
   input  logic              req_ready_i,
   output logic [ADDR_W-1:0] req_addr_o,
   input  logic              rsp_valid_i,
   input  logic              byte_ok_i,
   output logic [IDX_W-1:0]  idx_o,
   output logic              fifo_rst_o,
   output logic              err_clr_o,
   output logic              wr_en_o,
   output logic [LANE_W-1:0] wr_lane_o,
   output logic [CODE_W-1:0] wr_code_o,
   output logic [CODE_W-1:0] cur_code_o,
   output logic [LANE_W-1:0] act_lane_o,
   output logic              done_o,
   output logic [1:0]        result_o
);

   localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
   localparam logic [IDX_W-1:0]  IDX_LAST = IDX_W'(PAT_LEN - 1);

   seq_st_e           state_q, state_d;
   logic [CODE_W-1:0] cur_q, cur_d, wstart_q, wstart_d, wend_q, wend_d;
   logic [IDX_W-1:0]  idx_q, idx_d;
   logic [LANE_W-1:0] lane_q, lane_d;
   logic              phase_q, phase_d;
   train_res_e        res_q, res_d;
   logic              done_q, done_d;
   logic              cur_we, step_up;
   logic [CODE_W-1:0] span;

   assign span = wend_q - wstart_q;

   always_comb begin
      state_d  = state_q;
      cur_d    = cur_q;
      wstart_d = wstart_q;
      wend_d   = wend_q;
      idx_d    = idx_q;
      lane_d   = lane_q;
      phase_d  = phase_q;
      res_d    = res_q;
      done_d   = 1'b0;
      cur_we   = 1'b0;
      step_up  = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start_i) begin
               lane_d  = lane_i;
               cur_d   = '0;
               cur_we  = 1'b1;
               idx_d   = '0;
               phase_d = 1'b0;
               res_d   = RES_BUSY;
               state_d = ST_PREP;
            end
         end
         ST_PREP: state_d = ST_REQ;
         ST_REQ: begin
            if (req_ready_i) state_d = ST_WAIT;
         end
         ST_WAIT: begin
            if (rsp_valid_i) begin
               if (byte_ok_i) begin
                  if (idx_q != IDX_LAST) begin
                     idx_d   = idx_q + 1'b1;
                     state_d = ST_PREP;
                  end else if (!phase_q) begin
                     wstart_d = cur_q;
                     phase_d  = 1'b1;
                     idx_d    = '0;
                     state_d  = ST_PREP;
                  end else begin
                     step_up = 1'b1;
                  end
               end else if (!phase_q) begin
                  step_up = 1'b1;
               end else begin
                  wend_d  = cur_q;
                  state_d = ST_FIN;
               end
               if (step_up) begin
                  if (cur_q == CODE_MAX) begin
                     res_d   = RES_ERR;
                     done_d  = 1'b1;
                     state_d = ST_IDLE;
                  end else begin
                     cur_d   = cur_q + 1'b1;
                     cur_we  = 1'b1;
                     idx_d   = '0;
                     state_d = ST_PREP;
                  end
               end
            end
         end
         ST_FIN: begin
            cur_d   = wstart_q + (span >> 1);
            cur_we  = 1'b1;
            res_d   = RES_OK;
            done_d  = 1'b1;
            state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         cur_q    <= '0;
         wstart_q <= '0;
         wend_q   <= '0;
         idx_q    <= '0;
         lane_q   <= '0;
         phase_q  <= 1'b0;
         res_q    <= RES_OK;
         done_q   <= 1'b0;
      end else begin
         state_q  <= state_d;
         cur_q    <= cur_d;
         wstart_q <= wstart_d;
         wend_q   <= wend_d;
         idx_q    <= idx_d;
         lane_q   <= lane_d;
         phase_q  <= phase_d;
         res_q    <= res_d;
         done_q   <= done_d;
      end
   end

   assign req_valid_o = (state_q == ST_REQ);
   assign req_addr_o  = ADDR_W'(BASE) + ADDR_W'(lane_q)
                        + ADDR_W'(idx_q) * ADDR_W'(LANE_STRIDE);
   assign idx_o       = idx_q;
   assign fifo_rst_o  = (state_q == ST_PREP) || (state_q == ST_FIN);
   assign err_clr_o   = (state_q == ST_PREP);
   assign wr_en_o     = cur_we;
   assign wr_lane_o   = (state_q == ST_IDLE) ? lane_i : lane_q;
   assign wr_code_o   = cur_d;
   assign cur_code_o  = cur_q;
   assign act_lane_o  = lane_q;
   assign done_o      = done_q;
   assign result_o    = res_q;

   assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o)));

   assert_prep_before_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_valid_o) |-> $past(fifo_rst_o && err_clr_o));

   assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_done_not_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (result_o != RES_BUSY));

   assert_center_in_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FIN) |=> (cur_q >= wstart_q && cur_q <= wend_q));

   assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT && rsp_valid_i && cur_q == CODE_MAX) |=> (cur_q == CODE_MAX));

endmodule

// File: rtl/strobe_trainer.sv
module strobe_trainer
   import strb_pkg::*;
#(
   parameter int          LANES  = 4,
   parameter int          CODE_W = 5,
   parameter int          ADDR_W = 12,
   parameter logic [31:0] BASE   = 32'h100,
   localparam int         LANE_W = (LANES > 1) ? $clog2(LANES) : 1,
   localparam int         IDX_W  = $clog2(PAT_LEN)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start_i,
   input  logic [LANE_W-1:0]       lane_i,
   output logic                    rd_req_valid_o,
   input  logic                    rd_req_ready_i,
   output logic [ADDR_W-1:0]       rd_req_addr_o,
   input  logic                    rd_rsp_valid_i,
   input  logic [7:0]              rd_rsp_data_i,
   input  logic                    rd_rsp_masked_i,
   input  logic                    rd_rsp_dummy_i,
   output logic                    fifo_rst_o,
   output logic                    err_clr_o,
   output logic [LANES*CODE_W-1:0] dly_code_o,
   output logic                    done_o,
   output logic [1:0]              result_o
);

   if (LANES < 1 || LANES > LANE_STRIDE) begin : g_bad_lanes
      $error("strobe_trainer: LANES must lie in 1..LANE_STRIDE");
   end
   if (CODE_W < 2) begin : g_bad_code
      $error("strobe_trainer: CODE_W must be at least 2");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("strobe_trainer: ADDR_W too narrow");
   end

   logic [IDX_W-1:0]  idx;
   logic              byte_ok;
   logic              wr_en;
   logic [LANE_W-1:0] wr_lane, act_lane;
   logic [CODE_W-1:0] wr_code, cur_code;

   strb_byte_check #(.IDX_W(IDX_W)) u_check (
      .idx_i    (idx),
      .data_i   (rd_rsp_data_i),
      .masked_i (rd_rsp_masked_i),
      .dummy_i  (rd_rsp_dummy_i),
      .ok_o     (byte_ok)
   );

   strb_sweep_fsm #(
      .LANES(LANES), .CODE_W(CODE_W), .LANE_W(LANE_W),
      .IDX_W(IDX_W), .ADDR_W(ADDR_W), .BASE(BASE)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .lane_i      (lane_i),
      .req_valid_o (rd_req_valid_o),
      .req_ready_i (rd_req_ready_i),
      .req_addr_o  (rd_req_addr_o),
      .rsp_valid_i (rd_rsp_valid_i),
      .byte_ok_i   (byte_ok),
      .idx_o       (idx),
      .fifo_rst_o  (fifo_rst_o),
      .err_clr_o   (err_clr_o),
      .wr_en_o     (wr_en),
      .wr_lane_o   (wr_lane),
      .wr_code_o   (wr_code),
      .cur_code_o  (cur_code),
      .act_lane_o  (act_lane),
      .done_o      (done_o),
      .result_o    (result_o)
   );

   strb_lane_delays #(.LANES(LANES), .CODE_W(CODE_W), .LANE_W(LANE_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en),
      .wr_lane_i (wr_lane),
      .wr_code_i (wr_code),
      .codes_o   (dly_code_o)
   );

   assert_code_mirror_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (result_o == RES_BUSY) |-> (dly_code_o[act_lane*CODE_W +: CODE_W] == cur_code));

endmodule

// File: tb/tb_strobe_trainer.sv
module tb_strobe_trainer;

   localparam int LANES = 4;
   localparam int CW    = 5;
   localparam int AW    = 12;
   localparam int BASEA = 'h100;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [1:0]    lane_i = '0;
   logic          rd_req_valid_o;
   logic          rd_req_ready_i = 1'b0;
   logic [AW-1:0] rd_req_addr_o;
   logic          rd_rsp_valid_i = 1'b0;
   logic [7:0]    rd_rsp_data_i = '0;
   logic          rd_rsp_masked_i = 1'b0;
   logic          rd_rsp_dummy_i = 1'b0;
   logic          fifo_rst_o, err_clr_o, done_o;
   logic [LANES*CW-1:0] dly_code_o;
   logic [1:0]    result_o;

   always #2 clk = ~clk;

   strobe_trainer dut (.*);

   int n_chk = 0, n_bad = 0;
   int m_lane, m_lo, m_hi, m_ic, m_ii, m_ik;
   int reads, fifo_cnt, clr_cnt, addr_err, cyc;
   int exp_code [LANES];

   function automatic logic [7:0] ref_byte(int i);
      case (i)
         0: return 8'hFE; 1: return 8'h11; 2: return 8'h33; 3: return 8'h55;
         4: return 8'h77; 5: return 8'h99; 6: return 8'hBB; default: return 8'hDD;
      endcase
   endfunction

   function automatic int code_of(int ln);
      return int'(dly_code_o[ln*CW +: CW]);
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // memory-side model
   initial begin
      bit pend = 0;
      logic [7:0] pd;
      bit pm, pdm;
      forever begin
         @(negedge clk);
         cyc++;
         if (fifo_rst_o) fifo_cnt++;
         if (err_clr_o) clr_cnt++;
         rd_rsp_valid_i = 1'b0;
         if (pend) begin
            rd_rsp_valid_i = 1'b1; rd_rsp_data_i = pd;
            rd_rsp_masked_i = pm; rd_rsp_dummy_i = pdm; pend = 0;
         end
         rd_req_ready_i = (cyc % 3 != 1);
         if (rd_req_valid_o && rd_req_ready_i) begin
            int off, ln, ix, c;
            bit inwin, inj;
            off = int'(rd_req_addr_o) - BASEA;
            ln = off % 4; ix = off / 4;
            if (off < 0 || ln != m_lane || ix > 7) addr_err++;
            c = code_of(m_lane);
            inwin = (c >= m_lo) && (c <= m_hi);
            inj = (c == m_ic) && (ix == m_ii);
            pd  = (inwin && !(inj && m_ik == 0)) ? ref_byte(ix) : ~ref_byte(ix);
            pm  = inj && (m_ik == 1);
            pdm = inj && (m_ik == 2);
            pend = 1; reads++;
         end
      end
   end

   task automatic run_train(int ln, int lo, int hi, int ic, int ii, int ik,
                            int exp_res, int ecode, int ereads, int bump);
      int n = 0;
      m_lane = ln; m_lo = lo; m_hi = hi; m_ic = ic; m_ii = ii; m_ik = ik;
      @(negedge clk);
      reads = 0; fifo_cnt = 0; clr_cnt = 0; addr_err = 0;
      start_i = 1'b1; lane_i = 2'(ln);
      @(negedge clk);
      start_i = 1'b0;
      check(result_o == 2'b01, "R2 busy after start", int'(result_o), 1);
      check(code_of(ln) == 0, "R2 code forced to zero", code_of(ln), 0);
      while (!done_o && n < 20000) begin
         if (bump >= 0 && n == 30) begin start_i = 1'b1; lane_i = 2'(bump); end
         if (n == 31) start_i = 1'b0;
         @(negedge clk); n++;
      end
      check(done_o == 1'b1, "R11 done reached", int'(done_o), 1);
      check(int'(result_o) == exp_res, "R9/R10 result code", int'(result_o), exp_res);
      check(code_of(ln) == ecode, "R9/R10 final code", code_of(ln), ecode);
      for (int k = 0; k < LANES; k++)
         if (k != ln) check(code_of(k) == exp_code[k], "R12 other lane kept", code_of(k), exp_code[k]);
      check(addr_err == 0, "R3 request address", addr_err, 0);
      check(clr_cnt == reads, "R4 error clear per read", clr_cnt, reads);
      check(fifo_cnt == reads + (exp_res == 0 ? 1 : 0), "R4 fifo reset count",
            fifo_cnt, reads + (exp_res == 0 ? 1 : 0));
      if (ereads >= 0) check(reads == ereads, "R7/R8 read count", reads, ereads);
      @(negedge clk);
      check(done_o == 1'b0, "R11 done single cycle", int'(done_o), 0);
      check(int'(result_o) == exp_res, "R11 result held", int'(result_o), exp_res);
      exp_code[ln] = ecode;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
      $finish;
   end

   initial begin
      int los [8] = '{0, 1, 2, 7, 15, 29, 30, 31};
      int ws  [4] = '{0, 1, 2, 5};
      int k = 0;
      for (int i = 0; i < LANES; i++) exp_code[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(result_o == 2'b00, "R1 result after reset", int'(result_o), 0);
      check(done_o == 1'b0, "R1 done after reset", int'(done_o), 0);
      check(dly_code_o == '0, "R1 codes after reset", int'(dly_code_o), 0);
      check(!rd_req_valid_o && !fifo_rst_o && !err_clr_o, "R1 no activity",
            int'(rd_req_valid_o), 0);
      // R7 R8 R9 R10 window sweep
      foreach (los[a]) foreach (ws[b]) begin
         int lo = los[a], hi = los[a] + ws[b];
         int er, ec, ecnt;
         if (hi >= 31) begin
            hi = 31; er = 2; ec = 31; ecnt = lo + 8 + 8 * (32 - lo);
         end else begin
            er = 0; ec = lo + ((hi + 1 - lo) >> 1); ecnt = lo + 8 + 8 * (hi - lo + 1) + 1;
         end
         run_train(k % LANES, lo, hi, -1, 0, 0, er, ec, ecnt, -1);
         k++;
      end
      // R9 no window at all
      run_train(2, 40, 40, -1, 0, 0, 2, 31, 32, -1);
      // R6 masked flag with good data ends phase 1 late
      run_train(2, 3, 12, 3, 5, 1, 0, 8, -1, -1);
      // R6 dummy flag ends phase 2 early
      run_train(1, 2, 20, 9, 7, 2, 0, 5, -1, -1);
      // R7 data mismatch on the last byte restarts the pass
      run_train(3, 0, 6, 0, 7, 0, 0, 4, -1, -1);
      // R6 R9 flag kills the only passing code
      run_train(0, 4, 4, 4, 0, 1, 2, 31, 32, -1);
      // R12 second start during a run is ignored
      run_train(1, 5, 9, -1, 0, 0, 0, 7, 5 + 8 + 8 * 5 + 1, 3);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule